// File: doc/BRIEF.md
# MMIO Access Validation Decoder

This block stands between a memory-mapped bus port and a register bank and decides, in the cycle a request arrives, whether the access is legal. The region table is a set of elaboration-time parameters. Each region has a base offset, a length in bytes, a mask of the access widths it accepts, a bits-per-interrupt value and a kind. The kind is one of: normal, reads return zero, reads return ones, or writes dropped. Every region is compared against the request offset in parallel, which gives a one-hot hit vector. The size, alignment and interrupt-range rules then decide whether the access is legal.

A legal access to normal storage goes to the bank in the same cycle. The block gives the bank the region index, the offset relative to the region base, and the write value with its lowest-addressed byte in bits 7:0. The response is registered and appears one cycle later. It carries an error flag, and for reads it carries the data with each byte placed on its little-endian byte lane.

An access that is not legal never reaches the bank. It is answered locally: a read returns zero and the error flag is set.

Top module: `mmio_gate`

## Requirements
- R1: An offset hits region i when base_i <= offset < base_i + len_i. For a forwarded access, `bank_region` is i and `bank_offset` is offset - base_i. An offset that hits no region is rejected.
- R2: Only `req_size` values 1, 4 and 8 (bytes) are recognised. Any other value is rejected.
- R3: Each region has a 3-bit width mask: bit 0 allows 1-byte accesses, bit 1 allows 4-byte accesses and bit 2 allows 8-byte accesses. An access whose width bit is clear is rejected.
- R4: An access must be naturally aligned: a 4-byte access needs offset[1:0]=0 and an 8-byte access needs offset[2:0]=0. A misaligned access is rejected.
- R5: In a region with non-zero bits-per-interrupt b, the interrupt number is (offset - base)*8/b. The access is rejected unless that number is below `NUM_IRQ`. A region with b = 0 skips this check.
- R6: A rejected access raises `rsp_err` in its response and never asserts `bank_req`. A rejected read returns `rsp_rdata` = 0.
- R7: Kind code 1 (reads return zero) and kind code 2 (reads return ones) answer legal reads locally: code 1 returns 0, and code 2 returns ones in every byte of the access. Writes to either kind are dropped. None of these accesses is forwarded, and `rsp_err` stays 0.
- R8: Kind code 3 (writes dropped) forwards legal reads to the bank. It drops legal writes without forwarding them, and `rsp_err` stays 0. Kind code 0 (normal) forwards both reads and writes.
- R9: Bus byte lane k holds the byte at address (offset & ~7) + k. `bank_wdata` is the write bus shifted down by 8*offset[2:0] and masked to the access width. A legal read places the bank value, masked to the access width, at lanes offset[2:0] and upward. All other lanes are zero, and a write response carries zero data.
- R10: `bank_*` outputs follow the request in the same cycle, and `bank_req` is 0 when `req_valid` is 0. `rsp_valid`, `rsp_err` and `rsp_rdata` are registered one cycle after the request. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the block |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data in bus byte-lane order |
| bank_req | output | 1 | Access forwarded to the bank |
| bank_write | output | 1 | Forwarded access is a write |
| bank_region | output | RIDX_W | Index of the selected region |
| bank_offset | output | ADDR_W | Offset relative to the region base |
| bank_size | output | 4 | Access size in bytes |
| bank_wdata | output | 64 | Write value, lowest-addressed byte in bits 7:0 |
| bank_rdata | input | 64 | Bank read value, same cycle as `bank_req` |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was rejected |
| rsp_rdata | output | 64 | Read data in bus byte-lane order |

## Verification
The assertions assume three things about the block's environment. The region table has no overlapping regions. Request inputs are stable across each rising edge. The bank returns `bank_rdata` combinationally in the request cycle. The bench drives every request just after the falling edge, and its bank model is a pure function of `bank_region` and `bank_offset`. It sweeps every offset of the 4 KiB window with widths 0, 1, 2, 3, 4, 8 and 15 in both directions, using the default table, whose regions do not overlap.

// File: rtl/mmio_gate_pkg.sv
package mmio_gate_pkg;

    localparam int BUS_BYTES = 8;
    localparam int BUS_W     = BUS_BYTES * 8;

    typedef enum logic [1:0] {
        KIND_NORMAL = 2'd0,
        KIND_RAZ    = 2'd1,
        KIND_RAO    = 2'd2,
        KIND_WI     = 2'd3
    } region_kind_e;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [BUS_W-1:0] rdata;
    } rsp_t;

    // bit0: 1 byte, bit1: 4 bytes, bit2: 8 bytes; zero for anything else
    function automatic logic [2:0] size_onehot(input logic [3:0] nbytes);
        return {nbytes == 4'd8, nbytes == 4'd4, nbytes == 4'd1};
    endfunction

    function automatic logic [BUS_W-1:0] width_mask(input logic [2:0] oh);
        logic [BUS_W-1:0] m;
        case (oh)
            3'b001:  m = BUS_W'(64'hFF);
            3'b010:  m = BUS_W'(64'hFFFF_FFFF);
            3'b100:  m = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mmio_region_cmp.sv
module mmio_region_cmp #(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] BASE    = '0,
    parameter logic [ADDR_W:0]   LEN     = '0,
    parameter logic [2:0]        SIZES   = 3'b010,
    parameter logic [3:0]        BPI     = 4'd0,
    parameter int                NUM_IRQ = 64
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [2:0]        size_oh,
    output logic              hit,
    output logic              legal,
    output logic [ADDR_W-1:0] rel
);
    localparam logic [ADDR_W:0] LO_X = {1'b0, BASE};
    localparam logic [ADDR_W:0] HI_X = LO_X + LEN;
    localparam int              ID_W = ADDR_W + 3;

    logic size_ok;
    logic align_ok;
    logic id_ok;

    always_comb begin
        hit      = ({1'b0, offset} >= LO_X) && ({1'b0, offset} < HI_X);
        rel      = offset - BASE;
        size_ok  = |(size_oh & SIZES);
        align_ok = size_oh[2] ? (offset[2:0] == 3'd0) :
                   size_oh[1] ? (offset[1:0] == 2'd0) : 1'b1;
        legal    = hit && size_ok && align_ok && id_ok;
    end

    generate
        if (BPI == 4'd0) begin : g_no_irq
            assign id_ok = 1'b1;
        end else begin : g_irq
            localparam int SH = $clog2(int'(BPI));
            logic [ID_W-1:0] id_w;
            assign id_w  = {rel, 3'b000} >> SH;
            assign id_ok = id_w < ID_W'(NUM_IRQ);
        end
    endgenerate

endmodule

// File: rtl/mmio_lane_pack.sv
module mmio_lane_pack
    import mmio_gate_pkg::*;
(
    input  logic [2:0]       lane,
    input  logic [2:0]       size_oh,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [BUS_W-1:0] host_rdata,
    output logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    logic [BUS_W-1:0] mask;

    always_comb begin
        mask       = width_mask(size_oh);
        host_wdata = (bus_wdata >> {lane, 3'b000}) & mask;
        bus_rdata  = (host_rdata & mask) << {lane, 3'b000};
    end

endmodule

// File: rtl/mmio_gate.sv
module mmio_gate
    import mmio_gate_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NREG    = 7,
    parameter int NUM_IRQ = 64,
    parameter logic [NREG-1:0][ADDR_W-1:0] RG_BASE =
        {12'hC00, 12'h400, 12'h100, 12'h050, 12'h040, 12'h020, 12'h000},
    parameter logic [NREG-1:0][ADDR_W:0] RG_LEN =
        {13'h100, 13'h400, 13'h080, 13'h010, 13'h010, 13'h020, 13'h010},
    parameter logic [NREG-1:0][2:0] RG_SIZES =
        {3'b010, 3'b011, 3'b010, 3'b111, 3'b010, 3'b110, 3'b010},
    parameter logic [NREG-1:0][3:0] RG_BPI =
        {4'd2, 4'd8, 4'd1, 4'd0, 4'd0, 4'd0, 4'd0},
    parameter logic [NREG-1:0][1:0] RG_KIND =
        {2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0},
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              bank_req,
    output logic              bank_write,
    output logic [RIDX_W-1:0] bank_region,
    output logic [ADDR_W-1:0] bank_offset,
    output logic [3:0]        bank_size,
    output logic [BUS_W-1:0]  bank_wdata,
    input  logic [BUS_W-1:0]  bank_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [BUS_W-1:0]  rsp_rdata
);
    logic [2:0]        sz_oh;
    logic [NREG-1:0]   hit_vec;
    logic [NREG-1:0]   legal_vec;
    logic [ADDR_W-1:0] rel_arr [NREG];

    logic [RIDX_W-1:0] sel_idx;
    logic [ADDR_W-1:0] sel_rel;
    region_kind_e      sel_kind;
    logic              legal_any;
    logic              fwd;
    logic [BUS_W-1:0]  rd_val;
    logic [BUS_W-1:0]  rd_bus;

    rsp_t rsp_d, rsp_q;

    assign sz_oh = size_onehot(req_size);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_region
            mmio_region_cmp #(
                .ADDR_W  (ADDR_W),
                .BASE    (RG_BASE[g]),
                .LEN     (RG_LEN[g]),
                .SIZES   (RG_SIZES[g]),
                .BPI     (RG_BPI[g]),
                .NUM_IRQ (NUM_IRQ)
            ) u_cmp (
                .offset  (req_addr),
                .size_oh (sz_oh),
                .hit     (hit_vec[g]),
                .legal   (legal_vec[g]),
                .rel     (rel_arr[g])
            );
        end
    endgenerate

    // one-hot hit vector folded to index, relative offset and kind
    always_comb begin
        sel_idx  = '0;
        sel_rel  = '0;
        sel_kind = KIND_NORMAL;
        for (int i = 0; i < NREG; i++) begin
            if (hit_vec[i]) begin
                sel_idx  = RIDX_W'(i);
                sel_rel  = rel_arr[i];
                sel_kind = region_kind_e'(RG_KIND[i]);
            end
        end
        legal_any = |(hit_vec & legal_vec);
    end

    mmio_lane_pack u_lane (
        .lane       (req_addr[2:0]),
        .size_oh    (sz_oh),
        .bus_wdata  (req_wdata),
        .host_rdata (rd_val),
        .host_wdata (bank_wdata),
        .bus_rdata  (rd_bus)
    );

    always_comb begin
        fwd = req_valid && legal_any &&
              ((sel_kind == KIND_NORMAL) || ((sel_kind == KIND_WI) && !req_write));
        case (sel_kind)
            KIND_RAZ: rd_val = '0;
            KIND_RAO: rd_val = '1;
            default:  rd_val = bank_rdata;
        endcase
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && !legal_any;
        rsp_d.rdata = (req_valid && !req_write && legal_any) ? rd_bus : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bank_req    = fwd;
    assign bank_write  = req_write;
    assign bank_region = sel_idx;
    assign bank_offset = sel_rel;
    assign bank_size   = req_size;
    assign rsp_valid   = rsp_q.valid;
    assign rsp_err     = rsp_q.err;
    assign rsp_rdata   = rsp_q.rdata;

endmodule

// File: rtl/mmio_gate_chk.sv
module mmio_gate_chk #(
    parameter int ADDR_W = 12,
    parameter int NREG   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_size,
    input logic              bank_req,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic [NREG-1:0]   hit_vec
);
    a_r1_single_region: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r2_bad_size_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !(req_size inside {4'd1, 4'd4, 4'd8}) |-> !bank_req);

    a_r2_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !(req_size inside {4'd1, 4'd4, 4'd8}) |=> rsp_err);

    a_r4_misaligned_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_size == 4'd8) && (req_addr[2:0] != 3'd0) |-> !bank_req);

    a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_rdata == 64'd0);

    a_r9_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> rsp_rdata == 64'd0);

    a_r10_fwd_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req |-> req_valid);

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_err);

endmodule

bind mmio_gate mmio_gate_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .bank_req  (bank_req),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .hit_vec   (hit_vec)
);

// File: tb/mmio_gate_tb.sv
module mmio_gate_tb;
    localparam int ADDR_W  = 12;
    localparam int NREG    = 7;
    localparam int NUM_IRQ = 64;

    // bench copy of the default region table, from the requirements
    localparam int TB_BASE  [NREG] = '{'h000, 'h020, 'h040, 'h050, 'h100, 'h400, 'hC00};
    localparam int TB_LEN   [NREG] = '{'h10, 'h20, 'h10, 'h10, 'h80, 'h400, 'h100};
    localparam int TB_SIZES [NREG] = '{2, 6, 2, 7, 2, 3, 2};
    localparam int TB_BPI   [NREG] = '{0, 0, 0, 0, 1, 8, 2};
    localparam int TB_KIND  [NREG] = '{0, 1, 2, 3, 0, 0, 0};
    localparam int SZL      [7]    = '{0, 1, 2, 3, 4, 8, 15};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [3:0]        req_size;
    logic [63:0]       req_wdata;
    logic              bank_req;
    logic              bank_write;
    logic [2:0]        bank_region;
    logic [ADDR_W-1:0] bank_offset;
    logic [3:0]        bank_size;
    logic [63:0]       bank_wdata;
    logic [63:0]       bank_rdata;
    logic              rsp_valid;
    logic              rsp_err;
    logic [63:0]       rsp_rdata;

    int n_run  = 0;
    int n_fail = 0;
    int cur_addr = 0;
    int cur_size = 0;

    always #5 clk = ~clk;

    function automatic logic [63:0] bank_pattern(input logic [2:0] r, input logic [11:0] off);
        return 64'h0123_4567_89AB_CDEF ^ {5'd0, r, 44'd0, off};
    endfunction

    assign bank_rdata = bank_pattern(bank_region, bank_offset);

    mmio_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .bank_req(bank_req), .bank_write(bank_write), .bank_region(bank_region),
        .bank_offset(bank_offset), .bank_size(bank_size), .bank_wdata(bank_wdata),
        .bank_rdata(bank_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%03h size=%0d actual=%h expected=%h",
                     tag, cur_addr, cur_size, act, exp);
        end
    endtask

    function automatic logic [63:0] size_mask(input int sz);
        return (sz == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * sz)) - 64'd1);
    endfunction

    function automatic void model(input int a, input int sz, output bit legal,
                                  output int idx, output string why);
        int bit_w;
        idx   = -1;
        legal = 1'b0;
        for (int i = 0; i < NREG; i++)
            if (a >= TB_BASE[i] && a < TB_BASE[i] + TB_LEN[i]) idx = i;
        bit_w = (sz == 1) ? 1 : (sz == 4) ? 2 : 4;
        if (idx < 0)                                   why = "R1 unmatched";
        else if (!(sz == 1 || sz == 4 || sz == 8))     why = "R2 size";
        else if ((TB_SIZES[idx] & bit_w) == 0)         why = "R3 width flag";
        else if ((a % sz) != 0)                        why = "R4 alignment";
        else if (TB_BPI[idx] != 0 &&
                 ((a - TB_BASE[idx]) * 8 / TB_BPI[idx]) >= NUM_IRQ) why = "R5 irq range";
        else begin
            legal = 1'b1;
            case (TB_KIND[idx])
                1, 2:    why = "R7 local kind";
                3:       why = "R8 write drop";
                default: why = "R1 normal";
            endcase
        end
    endfunction

    task automatic do_acc(input int a, input int sz, input bit wr);
        bit          legal;
        int          idx;
        string       why;
        bit          exp_fwd;
        logic [63:0] wd, hv, exp_rd;
        int          lane;
        model(a, sz, legal, idx, why);
        lane = a % 8;
        wd   = {4{16'(a) ^ 16'h5A3C}} ^ 64'hF0E1_D2C3_B4A5_9687;
        exp_fwd = legal && (TB_KIND[idx] == 0 || (TB_KIND[idx] == 3 && !wr));
        exp_rd = 64'd0;
        if (legal && !wr) begin
            case (TB_KIND[idx])
                1:       hv = 64'd0;
                2:       hv = 64'hFFFF_FFFF_FFFF_FFFF;
                default: hv = bank_pattern(3'(idx), 12'(a - TB_BASE[idx]));
            endcase
            exp_rd = (hv & size_mask(sz)) << (8 * lane);
        end
        @(negedge clk);
        cur_addr  = a;
        cur_size  = sz;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(a);
        req_size  = 4'(sz);
        req_wdata = wd;
        #1;
        chk(legal ? why : {why, " R6 held"}, 64'(bank_req), 64'(exp_fwd));
        if (exp_fwd) begin
            chk("R1 region index", 64'(bank_region), 64'(idx));
            chk("R1 relative offset", 64'(bank_offset), 64'(a - TB_BASE[idx]));
            if (wr) chk("R9 write lanes", bank_wdata, (wd >> (8 * lane)) & size_mask(sz));
        end
        @(posedge clk);
        #1;
        chk("R10 response valid", 64'(rsp_valid), 64'd1);
        chk(legal ? why : {why, " R6 err"}, 64'(rsp_err), 64'(!legal));
        if (!legal)                              chk("R6 rejected data", rsp_rdata, exp_rd);
        else if (TB_KIND[idx] == 1 || TB_KIND[idx] == 2) chk("R7 local data", rsp_rdata, exp_rd);
        else                                     chk("R9 read lanes", rsp_rdata, exp_rd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R10 actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_size  = 4'd4;
        req_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset valid", 64'(rsp_valid), 64'd0);
        chk("R10 reset err", 64'(rsp_err), 64'd0);
        chk("R10 reset data", rsp_rdata, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // idle request on a legal address is not forwarded
        req_addr = 12'h100;
        #1;
        chk("R10 idle no forward", 64'(bank_req), 64'd0);
        @(posedge clk);
        #1;
        chk("R10 idle no response", 64'(rsp_valid), 64'd0);

        for (int a = 0; a < (1 << ADDR_W); a++)
            for (int s = 0; s < 7; s++) begin
                do_acc(a, SZL[s], 1'b0);
                do_acc(a, SZL[s], 1'b1);
            end

        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 response drops", 64'(rsp_valid), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule